// File: doc/BRIEF.md
# Cascaded Codec Channel Word Router

This block is the word-level serial-port controller of one channel in a daisy chain of codec channels. A host sends 16-bit words into the head of the chain. Each channel takes in one word per input frame strobe and decides what kind of word it is. It may consume the word, pass it on with its hop address lowered by one, or answer it with a register readback. A channel also emits its own ADC sample when a sample event arrives. Every emitted word is driven on the output port for one cycle, together with an output frame strobe. Because a channel's output feeds the next channel's input, a word addressed N hops down the chain reaches its target with a hop address of zero.

A word goes to one of four places. It can be a register write, a register read, a pass-through, or a DAC frame. Control register 0 holds the device count and two mode bits, and these decide how words are classified. DAC frames shift through a one-word holding slot. Each DAC frame sends the previously held word downstream and counts one frame. When the count reaches the device count, the newest DAC word is loaded into the DAC output latch. Bit-level shifting is modelled as one word per strobe. Input strobes must be spaced at least eight cycles apart, and a strobe that arrives while the controller is busy is not taken.

The controller is a single state machine with these states:
- ST_IDLE waits.
- ST_DECODE classifies the captured word.
- ST_CTRL_WRITE, ST_CTRL_READ, ST_CTRL_PASS and ST_DAC_FRAME each act on one class of word.
- ST_EMIT drives one output word.

The transitions are:
- ST_IDLE goes to ST_DECODE on an input strobe.
- ST_IDLE goes to ST_EMIT on a sample event, or on a sample event left pending.
- ST_DECODE goes to the action state for the word's class.
- ST_CTRL_WRITE returns to ST_IDLE.
- ST_CTRL_READ, ST_CTRL_PASS and ST_DAC_FRAME go to ST_EMIT.
- ST_EMIT returns to ST_IDLE.

Top module: `cascade_word_router`

## Requirements
- R1: After synchronous active-high reset, no output strobe is raised, the DAC latch reads 0, registers 1 to 7 read 0, and register 0 reads 0x09. In register 0, bits 2:0 are the device count (here 1), bit 3 is the program bit (here 1) and bit 4 is the mixed bit (here 0).
- R2: A control word is laid out as follows: bit 15 marks it as control, bit 14 requests a read, bits 13:11 hold the hop address, bits 10:8 select the register and bits 7:0 carry the data. When such a word arrives with hop address 000 and bit 14 clear, its data is written to the selected register and nothing is emitted.
- R3: A control word with a nonzero hop address is emitted exactly once. The hop address in the emitted word is one lower, and all other bits are unchanged. The output strobe is high for exactly one cycle.
- R4: A control word with hop address 000 and bit 14 set emits the word {1, 1, 111, select, register value}. No register is changed.
- R5: Words are classified by mode. With program=1 and mixed=0, every word is a control word. With program=1 and mixed=1, bit 15 decides: 1 means a control word and 0 means a DAC word. With program=0, every word is a DAC word.
- R6: The DAC latch changes only when the number of DAC frames counted reaches the device count. It then takes the newest DAC word. Control words do not advance the count.
- R7: Each DAC frame emits the DAC word held from the previous DAC frame unchanged, or 0 if no DAC frame has been held since reset. The new DAC word then becomes the held word.
- R8: After the DAC latch updates, the frame count restarts from zero. A further full set of device-count DAC frames is needed before the next update.
- R9: A sample event emits the ADC word present at that event. If the sample event comes together with an input strobe, the input word is handled first and the sample word is emitted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_fs | input | 1 | Input frame strobe |
| in_word | input | 16 | Input word |
| sample_tick | input | 1 | Sample event |
| adc_word | input | 16 | ADC word to send on a sample event |
| out_fs | output | 1 | Output frame strobe |
| out_word | output | 16 | Output word, valid while out_fs is high |
| dac_out | output | 16 | DAC output latch |
| dac_strobe | output | 1 | One-cycle pulse when the DAC latch updates |

## Verification
The bench puts a control word with its top bit clear into a channel in program mode. A design that classified words by bit 15 in every mode would update the DAC latch or consume that word instead of forwarding it. It interleaves a pass-through control word between DAC frames. A counter that advanced on every input strobe would then load the DAC latch one frame early. It sends a second pair of DAC frames after an update, which catches a frame count that is not cleared, and it reads back a hop-address-111 word in transit, which catches a decrement that wraps the wrong way or a read served at the wrong hop. A sample event that coincides with an input word must not be lost and must come out second.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    parameter int WORD_W = 16;
    parameter int ADDR_W = 3;
    parameter int SEL_W  = 3;
    parameter int DATA_W = 8;

    localparam int TYPE_BIT  = WORD_W - 1;
    localparam int RB_BIT    = WORD_W - 2;
    localparam int SEL_LSB   = DATA_W;
    localparam int ADDR_LSB  = SEL_W + DATA_W;
    localparam int NREG      = 2 ** SEL_W;
    localparam int CNT_W     = ADDR_W + 1;

    localparam int CFG_PGM_BIT = ADDR_W;
    localparam int CFG_MM_BIT  = ADDR_W + 1;
    localparam logic [DATA_W-1:0] CFG_RESET = DATA_W'((1 << CFG_PGM_BIT) | 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CTRL_WRITE,
        ST_CTRL_READ,
        ST_CTRL_PASS,
        ST_DAC_FRAME,
        ST_EMIT
    } state_t;

    typedef enum logic [1:0] {
        WK_DAC,
        WK_WRITE,
        WK_READ,
        WK_PASS
    } kind_t;
endpackage

// File: rtl/ccr_classify.sv
module ccr_classify
    import ccr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              pgm,
    input  logic              mm,
    output kind_t             kind
);
    logic              is_ctrl;
    logic [ADDR_W-1:0] hop;

    always_comb begin
        // program-only mode: all control; mixed: top bit decides; data: all DAC
        is_ctrl = pgm & (~mm | word[TYPE_BIT]);
        hop     = word[ADDR_LSB +: ADDR_W];
        if (!is_ctrl) begin
            kind = WK_DAC;
        end else if (hop == '0) begin
            kind = word[RB_BIT] ? WK_READ : WK_WRITE;
        end else begin
            kind = WK_PASS;
        end
    end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dev_count,
    output logic              pgm,
    output logic              mm
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? CFG_RESET : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (sel == SEL_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data   = regs[sel];
        dev_count = regs[0][ADDR_W-1:0];
        pgm       = regs[0][CFG_PGM_BIT];
        mm        = regs[0][CFG_MM_BIT];
    end
endmodule

// File: rtl/ccr_dac_ctl.sv
module ccr_dac_ctl
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_en,
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] dev_count,
    output logic [WORD_W-1:0] held_word,
    output logic [WORD_W-1:0] dac_out,
    output logic              dac_strobe
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  target;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] dac_q;
    logic              strobe_q;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        // a device count of zero stands for the largest chain length
        target  = (dev_count == '0) ? CNT_W'(2 ** ADDR_W) : {1'b0, dev_count};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            hold_q   <= '0;
            dac_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (frame_en) begin
                hold_q <= word;
                if (cnt_inc == target) begin
                    cnt_q    <= '0;
                    dac_q    <= word;
                    strobe_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end

    assign held_word  = hold_q;
    assign dac_out    = dac_q;
    assign dac_strobe = strobe_q;
endmodule

// File: rtl/cascade_word_router.sv
module cascade_word_router
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fs,
    input  logic [WORD_W-1:0] in_word,
    input  logic              sample_tick,
    input  logic [WORD_W-1:0] adc_word,
    output logic              out_fs,
    output logic [WORD_W-1:0] out_word,
    output logic [WORD_W-1:0] dac_out,
    output logic              dac_strobe
);
    state_t            state_q, state_d;
    kind_t             kind;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] obuf_q;
    logic [WORD_W-1:0] adc_q;
    logic              pend_q;
    logic              reg_wr_en;
    logic              dac_frame;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] dev_count;
    logic              pgm, mm;
    logic [WORD_W-1:0] held_word;
    logic [ADDR_W-1:0] hop_dec;
    logic              take_sample;

    ccr_classify u_cls (
        .word (word_q),
        .pgm  (pgm),
        .mm   (mm),
        .kind (kind)
    );

    ccr_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .sel       (word_q[SEL_LSB +: SEL_W]),
        .wr_data   (word_q[DATA_W-1:0]),
        .rd_data   (rd_data),
        .dev_count (dev_count),
        .pgm       (pgm),
        .mm        (mm)
    );

    ccr_dac_ctl u_dac (
        .clk        (clk),
        .rst        (rst),
        .frame_en   (dac_frame),
        .word       (word_q),
        .dev_count  (dev_count),
        .held_word  (held_word),
        .dac_out    (dac_out),
        .dac_strobe (dac_strobe)
    );

    always_comb begin
        hop_dec     = word_q[ADDR_LSB +: ADDR_W] - ADDR_W'(1);
        take_sample = (state_q == ST_IDLE) && !in_fs && (sample_tick || pend_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_fs) begin
                    state_d = ST_DECODE;
                end else if (sample_tick || pend_q) begin
                    state_d = ST_EMIT;
                end
            end
            ST_DECODE: begin
                unique case (kind)
                    WK_DAC:   state_d = ST_DAC_FRAME;
                    WK_WRITE: state_d = ST_CTRL_WRITE;
                    WK_READ:  state_d = ST_CTRL_READ;
                    WK_PASS:  state_d = ST_CTRL_PASS;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_CTRL_WRITE: state_d = ST_IDLE;
            ST_CTRL_READ:  state_d = ST_EMIT;
            ST_CTRL_PASS:  state_d = ST_EMIT;
            ST_DAC_FRAME:  state_d = ST_EMIT;
            ST_EMIT:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes decoded from state
    always_comb begin
        out_fs    = (state_q == ST_EMIT);
        out_word  = obuf_q;
        reg_wr_en = (state_q == ST_CTRL_WRITE);
        dac_frame = (state_q == ST_DAC_FRAME);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            obuf_q <= '0;
            adc_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (sample_tick) begin
                adc_q <= adc_word;
            end
            if (take_sample) begin
                pend_q <= 1'b0;
                obuf_q <= sample_tick ? adc_word : adc_q;
            end else if (sample_tick) begin
                pend_q <= 1'b1;
            end
            if ((state_q == ST_IDLE) && in_fs) begin
                word_q <= in_word;
            end
            unique case (state_q)
                ST_CTRL_READ: begin
                    obuf_q <= {1'b1, 1'b1, {ADDR_W{1'b1}},
                               word_q[SEL_LSB +: SEL_W], rd_data};
                end
                ST_CTRL_PASS: begin
                    obuf_q <= {word_q[WORD_W-1:ADDR_LSB+ADDR_W], hop_dec,
                               word_q[ADDR_LSB-1:0]};
                end
                ST_DAC_FRAME: begin
                    obuf_q <= held_word;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_fs,
    input logic [WORD_W-1:0] dac_out,
    input logic              dac_strobe,
    input logic              wr_en
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_fs); // R1

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !out_fs); // R2

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_fs |=> !out_fs); // R3

    AST_DAC_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_out) |-> dac_strobe); // R6

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        dac_strobe |=> !dac_strobe); // R8
endmodule

bind cascade_word_router ccr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_fs     (out_fs),
    .dac_out    (dac_out),
    .dac_strobe (dac_strobe),
    .wr_en      (reg_wr_en)
);

// File: tb/tb_cascade_word_router.sv
module tb_cascade_word_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_fs;
    logic [15:0] in_word;
    logic        sample_tick;
    logic [15:0] adc_word;
    logic        out_fs;
    logic [15:0] out_word;
    logic [15:0] dac_out;
    logic        dac_strobe;

    int checks = 0;
    int errors = 0;
    int cap_n  = 0;
    int rd_i   = 0;
    bit done   = 0;
    logic [15:0] cap [0:63];

    always #5 clk = ~clk;

    cascade_word_router dut (
        .clk(clk), .rst(rst), .in_fs(in_fs), .in_word(in_word),
        .sample_tick(sample_tick), .adc_word(adc_word),
        .out_fs(out_fs), .out_word(out_word),
        .dac_out(dac_out), .dac_strobe(dac_strobe)
    );

    always @(negedge clk) begin
        if (!rst && out_fs && cap_n < 64) begin
            cap[cap_n] = out_word;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic [15:0] exp);
        if (rd_i < cap_n) begin
            chk(cap[rd_i] == exp, tag, cap[rd_i], exp);
            rd_i++;
        end else begin
            chk(1'b0, tag, 16'hxxxx, exp);
        end
    endtask

    task automatic expect_none(input string tag);
        chk(cap_n == rd_i, tag, 16'(cap_n - rd_i), 16'h0);
        rd_i = cap_n;
    endtask

    task automatic send(input logic [15:0] w, input bit with_sample, input logic [15:0] adc);
        @(negedge clk);
        in_fs = 1'b1; in_word = w;
        sample_tick = with_sample; adc_word = adc;
        @(negedge clk);
        in_fs = 1'b0; sample_tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic sample_only(input logic [15:0] adc);
        @(negedge clk);
        sample_tick = 1'b1; adc_word = adc;
        @(negedge clk);
        sample_tick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(out_fs == 1'b0, "R1 out_fs low", {15'd0, out_fs}, 16'h0);
        chk(dac_out == 16'h0, "R1 dac latch", dac_out, 16'h0);
        send(16'hC000, 0, 0);
        expect_out("R1 reg0 reset value", 16'hF809);
        send(16'hC300, 0, 0);
        expect_out("R1 reg3 reset value", 16'hFB00);
    endtask

    task automatic t_forward;
        send(16'h9A55, 0, 0);
        expect_out("R3 hop 011 forwarded as 010", 16'h9255);
        send(16'hF812, 0, 0);
        expect_out("R3 R4 hop 111 read passes as 110", 16'hF012);
        expect_none("R3 single emission");
    endtask

    task automatic t_write_read;
        send(16'h853C, 0, 0);
        expect_none("R2 write consumed");
        send(16'hC500, 0, 0);
        expect_out("R4 readback reg5", 16'hFD3C);
        send(16'hC500, 0, 0);
        expect_out("R4 readback leaves reg5", 16'hFD3C);
    endtask

    task automatic t_program_mode;
        send(16'h1234, 0, 0);
        expect_out("R5 program mode top-bit-0 word is control", 16'h0A34);
        chk(dac_out == 16'h0, "R5 no DAC in program mode", dac_out, 16'h0);
        send(16'h801A, 0, 0);
        expect_none("R2 reg0 write");
        send(16'hC000, 0, 0);
        expect_out("R5 mixed mode set", 16'hF81A);
    endtask

    task automatic t_dac;
        send(16'h1111, 0, 0);
        expect_out("R7 first held word zero", 16'h0000);
        chk(dac_out == 16'h0, "R6 latch waits for count", dac_out, 16'h0);
        send(16'h8800, 0, 0);
        expect_out("R5 mixed control forwarded", 16'h8000);
        chk(dac_out == 16'h0, "R6 control word not counted", dac_out, 16'h0);
        send(16'h2222, 0, 0);
        expect_out("R7 forwards held DAC word", 16'h1111);
        chk(dac_out == 16'h2222, "R6 latch on count reached", dac_out, 16'h2222);
        send(16'h3333, 0, 0);
        expect_out("R7 forward after update", 16'h2222);
        chk(dac_out == 16'h2222, "R8 counter restarted", dac_out, 16'h2222);
        send(16'h4444, 0, 0);
        expect_out("R7 forward second pair", 16'h3333);
        chk(dac_out == 16'h4444, "R8 second update", dac_out, 16'h4444);
    endtask

    task automatic t_sample;
        sample_only(16'hABCD);
        expect_out("R9 sample word emitted", 16'hABCD);
        send(16'h9A55, 1, 16'h5A5A);
        expect_out("R9 input word first", 16'h9255);
        expect_out("R9 deferred sample second", 16'h5A5A);
        expect_none("R9 nothing more");
    endtask

    task automatic t_data_mode;
        send(16'h8001, 0, 0);
        expect_none("R2 switch to data mode");
        send(16'h8123, 0, 0);
        expect_out("R5 data mode word treated as DAC", 16'h4444);
        chk(dac_out == 16'h8123, "R5 R6 data mode latch count 1", dac_out, 16'h8123);
    endtask

    initial begin
        rst = 1'b1; in_fs = 1'b0; in_word = '0; sample_tick = 1'b0; adc_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_forward();
        t_write_read();
        t_program_mode();
        t_dac();
        t_sample();
        t_data_mode();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule